// File: doc/BRIEF.md
# Flash Command Launch Status Register

This block is the 8-bit status and control register between a bus-mapped register port and a flash command engine. Software reads it to learn whether the engine is idle, whether the last command ended in an error, and what result that command returned. Software writes it to clear latched error flags and to start a new command.

A command starts when software writes a one into the completion flag. A launch is refused while an access error or a protection violation is still latched, so software has to clear those first. The engine side is a set of handshake strobes: initialisation done, command done, access error, protection violation and read collision, plus a one-bit result. The block drives a one-cycle launch strobe and a level interrupt request.

Reset is asserted asynchronously and released synchronously through a short synchronizer. After release, every bit reads zero until the engine signals that its initialisation is done.

Top module: `fcs_status_reg`

## Requirements
- R1: The read value places the completion flag in bit 7, read collision in bit 6, access error in bit 5, protection violation in bit 4 and the command result in bit 0. Bits 3 to 1 always read 0, and writing them has no effect.
- R2: After reset all eight bits read 0 and no launch or interrupt is produced. The first init-done strobe sets bit 7 at the next clock edge, and later init-done strobes have no effect.
- R3: Bits 7 to 4 are write-one-to-clear. A zero written to any of them leaves it unchanged.
- R4: Writing 1 to bit 7 while it is 1 and bits 5 and 4 are 0 clears bit 7 and raises `launch` for exactly one cycle, starting at the same clock edge.
- R5: While bit 5 or bit 4 is set, writing 1 to bit 7 produces no launch and leaves bit 7 at 1, even when the same write clears those error bits.
- R6: While a command is running (bit 7 is 0), bit 7 stays 0 until the engine reports done or an error, and writing 1 to bit 7 has no effect.
- R7: An access-error or protection-violation strobe during a running command sets bit 5 or bit 4 and returns bit 7 to 1 at the same edge. These strobes are ignored when no command is running.
- R8: Bit 0 takes the engine result at the edge where a running command completes. At any other time it holds, and register writes never change it.
- R9: The read-collision strobe sets bit 6 whatever the command state. When a set and a software clear arrive in the same cycle, the set wins.
- R10: `irq` is high exactly while bit 7 is 1 and `irq_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Current register value |
| irq_en | input | 1 | Interrupt enable |
| eng_init_done | input | 1 | Engine finished post-reset initialisation |
| eng_cmd_done | input | 1 | Engine finished the running command |
| eng_acc_err | input | 1 | Engine detected an access error |
| eng_prot_err | input | 1 | Engine detected a protection violation |
| eng_rd_coll | input | 1 | Engine detected a read collision |
| eng_result | input | 1 | Command result, valid with eng_cmd_done |
| launch | output | 1 | One-cycle command start strobe |
| irq | output | 1 | Interrupt request |

## Verification
The cases that are hardest to reach from the ports are the same-cycle collisions: a software write that clears an error flag while also trying to launch, and a hardware read-collision set that lands in the same cycle as a software clear of that flag. The stimulus reaches them by driving the engine strobes and the register write in the same cycle. The error strobes are also sent when no command is running, so that the busy gating is exercised in both directions. The command result bit is carried across a further launch and across a stray done strobe, to show that it changes only when a running command completes.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int REG_W   = 8;
  localparam int CC_BIT  = 7;  // completion / launch
  localparam int RC_BIT  = 6;  // read collision
  localparam int AE_BIT  = 5;  // access error
  localparam int PV_BIT  = 4;  // protection violation
  localparam int RS_BIT  = 0;  // command result
  localparam int NUM_ERR = 3;  // flags at PV_BIT .. RC_BIT
  // index into the error flag vector; bit position = PV_BIT + index
  typedef enum logic [1:0] {
    ERR_PV = 2'd0,
    ERR_AE = 2'd1,
    ERR_RC = 2'd2
  } err_idx_e;
endpackage

// File: rtl/fcs_rst_sync.sv
module fcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/fcs_w1c_flag.sv
module fcs_w1c_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set_i | clr_i;
    flag_d  = set_i;        // set dominates a same-cycle clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign flag_o = flag_q;

  // R9 / R7: a hardware set always lands
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o);
  // R3: with no strobe the flag holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(flag_o));
endmodule

// File: rtl/fcs_cmd_ctl.sv
module fcs_cmd_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic init_done_i,
  input  logic wr_launch_i,
  input  logic err_block_i,
  input  logic cmd_done_i,
  input  logic cmd_err_i,
  input  logic result_i,
  output logic ccif_o,
  output logic busy_o,
  output logic launch_o,
  output logic result_o
);
  logic init_q, init_d;
  logic ccif_q, ccif_d, ccif_en;
  logic launch_q, launch_d;
  logic res_q, res_en;
  logic busy;
  logic launch_ok;
  logic finish;

  always_comb begin
    busy      = init_q & ~ccif_q;
    launch_ok = wr_launch_i & ccif_q & ~err_block_i;
    finish    = busy & (cmd_done_i | cmd_err_i);
    init_d    = init_q | init_done_i;
    launch_d  = launch_ok;
    res_en    = busy & cmd_done_i;
    ccif_en   = 1'b0;
    ccif_d    = ccif_q;
    if (!init_q) begin
      ccif_en = init_done_i;
      ccif_d  = 1'b1;
    end else if (launch_ok) begin
      ccif_en = 1'b1;
      ccif_d  = 1'b0;
    end else if (finish) begin
      ccif_en = 1'b1;
      ccif_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_q   <= 1'b0;
      ccif_q   <= 1'b0;
      launch_q <= 1'b0;
      res_q    <= 1'b0;
    end else begin
      init_q   <= init_d;
      launch_q <= launch_d;
      if (ccif_en) ccif_q <= ccif_d;
      if (res_en)  res_q  <= result_i;
    end
  end

  assign ccif_o   = ccif_q;
  assign busy_o   = busy;
  assign launch_o = launch_q;
  assign result_o = res_q;

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |=> !launch_o);
  a_r4_flag_drops: assert property (@(posedge clk) disable iff (!rst_n)
    launch_o |-> !ccif_o);
  a_r6_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !cmd_done_i && !cmd_err_i) |=> !ccif_o);
  a_r7_err_returns: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cmd_err_i) |=> ccif_o);
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && cmd_done_i) |=> $stable(result_o));
endmodule

// File: rtl/fcs_status_reg.sv
module fcs_status_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       irq_en,
  input  logic       eng_init_done,
  input  logic       eng_cmd_done,
  input  logic       eng_acc_err,
  input  logic       eng_prot_err,
  input  logic       eng_rd_coll,
  input  logic       eng_result,
  output logic       launch,
  output logic       irq
);
  import fcs_pkg::*;

  logic               rst_n_i;
  logic               ccif, busy, result;
  logic [NUM_ERR-1:0] err_set, err_clr, err_flag;
  logic               unused_wr_bits;

  fcs_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  always_comb begin
    err_set[ERR_PV] = busy & eng_prot_err;
    err_set[ERR_AE] = busy & eng_acc_err;
    err_set[ERR_RC] = eng_rd_coll;
  end

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
    assign err_clr[i] = wr_en & wr_data[PV_BIT + i];
    fcs_w1c_flag u_flag (
      .clk    (clk),
      .rst_n  (rst_n_i),
      .set_i  (err_set[i]),
      .clr_i  (err_clr[i]),
      .flag_o (err_flag[i])
    );
  end

  fcs_cmd_ctl u_ctl (
    .clk         (clk),
    .rst_n       (rst_n_i),
    .init_done_i (eng_init_done),
    .wr_launch_i (wr_en & wr_data[CC_BIT]),
    .err_block_i (err_flag[ERR_AE] | err_flag[ERR_PV]),
    .cmd_done_i  (eng_cmd_done),
    .cmd_err_i   (eng_acc_err | eng_prot_err),
    .result_i    (eng_result),
    .ccif_o      (ccif),
    .busy_o      (busy),
    .launch_o    (launch),
    .result_o    (result)
  );

  always_comb begin
    rd_data         = '0;
    rd_data[CC_BIT] = ccif;
    rd_data[RC_BIT] = err_flag[ERR_RC];
    rd_data[AE_BIT] = err_flag[ERR_AE];
    rd_data[PV_BIT] = err_flag[ERR_PV];
    rd_data[RS_BIT] = result;
  end

  assign irq            = ccif & irq_en;
  assign unused_wr_bits = ^wr_data[3:0];

  a_r5_blocked: assert property (@(posedge clk) disable iff (!rst_n_i)
    (wr_en && wr_data[CC_BIT] && (rd_data[AE_BIT] || rd_data[PV_BIT])) |=> !launch);
  a_r7_idle_err_ignored: assert property (@(posedge clk) disable iff (!rst_n_i)
    (rd_data[CC_BIT] && !rd_data[AE_BIT] && !(wr_en && wr_data[CC_BIT])) |=> !rd_data[AE_BIT]);
endmodule

// File: tb/tb_fcs_status_reg.sv
`timescale 1ns/1ps
module tb_fcs_status_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       irq_en = 1'b0;
  logic       eng_init_done = 1'b0, eng_cmd_done = 1'b0, eng_acc_err = 1'b0;
  logic       eng_prot_err = 1'b0, eng_rd_coll = 1'b0, eng_result = 1'b0;
  logic [7:0] rd_data;
  logic       launch, irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit done_run = 0;

  typedef struct {
    logic [7:0] rd;
    logic       ln;
    logic       iq;
    string      tag;
  } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;  // 125 MHz

  fcs_status_reg dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .irq_en(irq_en), .eng_init_done(eng_init_done), .eng_cmd_done(eng_cmd_done),
    .eng_acc_err(eng_acc_err), .eng_prot_err(eng_prot_err), .eng_rd_coll(eng_rd_coll),
    .eng_result(eng_result), .launch(launch), .irq(irq)
  );

  task automatic check(input string tag, input logic [9:0] act, input logic [9:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual rd=%h launch=%b irq=%b expected rd=%h launch=%b irq=%b",
               tag, act[9:2], act[1], act[0], exp[9:2], exp[1], exp[0]);
    end
  endtask

  // monitor: compares results just after the edge they belong to
  always @(posedge clk) begin
    #1;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      check(e.tag, {rd_data, launch, irq}, {e.rd, e.ln, e.iq});
    end
  end

  // driver: eng = {init, done, acc, prot, rdcoll, result}
  task automatic step(input logic we, input logic [7:0] wd, input logic [5:0] eng,
                      input logic ien, input logic [7:0] e_rd, input logic e_ln,
                      input logic e_iq, input string tag);
    exp_t e;
    @(negedge clk);
    wr_en = we; wr_data = wd; irq_en = ien;
    {eng_init_done, eng_cmd_done, eng_acc_err, eng_prot_err, eng_rd_coll, eng_result} = eng;
    @(posedge clk);
    e.rd = e_rd; e.ln = e_ln; e.iq = e_iq; e.tag = tag;
    sb_q.push_back(e);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_run) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    irq_en = 1'b1;
    repeat (3) @(posedge clk);
    #1 check("R2 reset state", {rd_data, launch, irq}, {8'h00, 1'b0, 1'b0});
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 8'h00, 6'b000000, 1, 8'h00, 0, 0, "R2 before init");
    step(0, 8'h00, 6'b100000, 1, 8'h80, 0, 1, "R2 init sets bit7 / R10 irq");
    step(0, 8'h00, 6'b000000, 0, 8'h80, 0, 0, "R10 irq masked");
    step(1, 8'h0F, 6'b000000, 1, 8'h80, 0, 1, "R1 bits 3:0 not writable");
    step(1, 8'h70, 6'b000000, 1, 8'h80, 0, 1, "R3 clear of clear flags");
    step(1, 8'h80, 6'b000000, 1, 8'h00, 1, 0, "R4 launch");
    step(0, 8'h00, 6'b000000, 1, 8'h00, 0, 0, "R4 one-cycle pulse");
    step(1, 8'h80, 6'b000000, 1, 8'h00, 0, 0, "R6 write while busy");
    step(0, 8'h00, 6'b100000, 1, 8'h00, 0, 0, "R2 later init ignored");
    step(0, 8'h00, 6'b010001, 1, 8'h81, 0, 1, "R8 result on done");
    step(1, 8'h81, 6'b000000, 1, 8'h01, 1, 0, "R4 relaunch / R8 result held");
    step(0, 8'h00, 6'b001000, 1, 8'hA1, 0, 1, "R7 access error");
    step(1, 8'h80, 6'b000000, 1, 8'hA1, 0, 1, "R5 blocked by access error");
    step(1, 8'hA0, 6'b000000, 1, 8'h81, 0, 1, "R5 clear does not launch");
    step(1, 8'h80, 6'b000000, 1, 8'h01, 1, 0, "R4 launch after clear");
    step(0, 8'h00, 6'b010100, 1, 8'h90, 0, 1, "R7 protection error / R8");
    step(1, 8'h80, 6'b000000, 1, 8'h90, 0, 1, "R5 blocked by protection");
    step(1, 8'h00, 6'b000000, 1, 8'h90, 0, 1, "R3 zeros no effect");
    step(1, 8'h10, 6'b000000, 1, 8'h80, 0, 1, "R3 w1c bit4");
    step(0, 8'h00, 6'b000010, 1, 8'hC0, 0, 1, "R9 rd collision idle");
    step(1, 8'h40, 6'b000010, 1, 8'hC0, 0, 1, "R9 set beats clear");
    step(1, 8'h40, 6'b000000, 1, 8'h80, 0, 1, "R3 w1c bit6");
    step(1, 8'h80, 6'b000000, 1, 8'h00, 1, 0, "R4 launch");
    step(0, 8'h00, 6'b000010, 1, 8'h40, 0, 0, "R9 rd collision busy");
    step(1, 8'hC0, 6'b000000, 1, 8'h00, 0, 0, "R6 bit7 write busy / R3");
    step(0, 8'h00, 6'b010001, 1, 8'h81, 0, 1, "R8 result on done");
    step(0, 8'h00, 6'b010000, 1, 8'h81, 0, 1, "R8 stray done ignored");
    step(0, 8'h00, 6'b001100, 1, 8'h81, 0, 1, "R7 idle error ignored");
    @(negedge clk);
    wr_en = 1'b0; {eng_init_done, eng_cmd_done, eng_acc_err, eng_prot_err, eng_rd_coll, eng_result} = '0;
    rst_n = 1'b0;
    #1 check("R2 async reset", {rd_data, launch, irq}, {8'h00, 1'b0, 1'b0});
    repeat (3) @(posedge clk);
    #2;
    if (sb_q.size() != 0) check("scoreboard drained", {2'b0, 8'(sb_q.size())}, 10'd0);
    done_run = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule